// File: doc/BRIEF.md
# Next fetch address selector with return address stack

This block picks the address that instruction fetch uses in the following cycle. It is combinational from its inputs to its output. It takes the current fetch PC and the lookup result from the branch target buffer, which gives a hit flag, a two-bit branch kind and a stored target. It also takes the taken or not-taken guess of the direction predictor. A PC that misses the buffer is treated as an ordinary instruction, and fetch moves on by four bytes. A hit chooses its next PC according to the branch kind.

The block holds a small circular stack of return addresses. A predicted call pushes its own PC + 4 onto the stack. A predicted return pops the stack and uses the popped value as its target, so nested calls unwind in reverse order. A redirect from branch resolution overrides every prediction for that cycle and leaves the stack untouched. Filling the target buffer and training the predictor are handled elsewhere.

Top module: `next_pc_sel`

## Requirements
- R1: When the buffer misses (`btb_hit_i`=0) and no redirect is present, `next_pc_o` equals `pc_i` + 4.
- R2: On a hit with kind 2'b01 (unconditional jump), `next_pc_o` is `btb_target_i` whatever `dir_taken_i` is, and the return stack does not change.
- R3: On a hit with kind 2'b00 (conditional), `next_pc_o` is `btb_target_i` when `dir_taken_i`=1 and `pc_i` + 4 when it is 0. The stack does not change.
- R4: On a hit with kind 2'b10 (call), `next_pc_o` is `btb_target_i` whatever `dir_taken_i` is, and `pc_i` + 4 is pushed on the stack at the clock edge.
- R5: On a hit with kind 2'b11 (return) while the stack holds at least one entry, `next_pc_o` is the most recently pushed address, and that entry is removed at the clock edge.
- R6: Nested calls followed by returns give each return the address of its most recent outstanding call, in last-in first-out order.
- R7: A call made while the stack holds DEPTH entries drops the oldest entry. The stack then still holds the DEPTH most recent return addresses.
- R8: A return that finds the stack empty uses `btb_target_i` as `next_pc_o` and leaves the stack empty.
- R9: When `redirect_i`=1, `next_pc_o` equals `redirect_pc_i` in that cycle, and the stack neither pushes nor pops.
- R10: After reset the stack is empty, so the first return falls back to `btb_target_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | AW | Current fetch PC |
| btb_hit_i | input | 1 | Branch target buffer hit |
| btb_kind_i | input | 2 | Branch kind: 00 conditional, 01 jump, 10 call, 11 return |
| btb_target_i | input | AW | Stored target from the buffer |
| dir_taken_i | input | 1 | Direction predictor says taken |
| redirect_i | input | 1 | Resolution redirect request |
| redirect_pc_i | input | AW | Redirect address |
| next_pc_o | output | AW | Chosen next fetch PC |

## Verification
The assertions assume that every cycle presents exactly one fetch PC. They also assume that the kind field is meaningful only while the hit flag is set, and that a redirect makes the predicted branch in the same cycle void. The call-then-return property further assumes that a return may directly follow a call. The random stimulus produces only word-aligned PCs and targets and mixes all four kinds with misses. It raises redirects in about one cycle in ten. Directed sequences take the stack past full and then drain it past empty, so both the overwrite path and the fallback path are exercised.

// File: rtl/next_pc_pkg.sv
package next_pc_pkg;
  typedef enum logic [1:0] {
    BK_COND = 2'b00,
    BK_JUMP = 2'b01,
    BK_CALL = 2'b10,
    BK_RET  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/npc_ras.sv
module npc_ras #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic [AW-1:0]                 push_addr_i,
  output logic [AW-1:0]                 top_o,
  output logic                          empty_o,
  output logic [$clog2(DEPTH+1)-1:0]    count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ptr_inc, ptr_dec;

  // wrap helpers that work for any depth
  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH-1) : p - 1'b1;
  endfunction

  assign ptr_inc = wrap_inc(wr_ptr_q);
  assign ptr_dec = wrap_dec(wr_ptr_q);
  assign top_o   = slot_q[ptr_dec];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      slot_q[wr_ptr_q] <= push_addr_i;
      wr_ptr_q         <= ptr_inc;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      wr_ptr_q <= ptr_dec;
      cnt_q    <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/npc_choose.sv
module npc_choose
  import next_pc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          [AW-1:0] pc_i,
  input  logic                   hit_i,
  input  br_kind_e               kind_i,
  input  logic          [AW-1:0] target_i,
  input  logic                   taken_i,
  input  logic                   redirect_i,
  input  logic          [AW-1:0] redirect_pc_i,
  input  logic          [AW-1:0] ras_top_i,
  input  logic                   ras_empty_i,
  output logic          [AW-1:0] next_pc_o,
  output logic          [AW-1:0] link_addr_o,
  output logic                   push_o,
  output logic                   pop_o
);
  function automatic logic [AW-1:0] seq_pc(input logic [AW-1:0] p);
    return p + AW'(4);
  endfunction

  assign link_addr_o = seq_pc(pc_i);
  assign push_o = !redirect_i && hit_i && (kind_i == BK_CALL);
  assign pop_o  = !redirect_i && hit_i && (kind_i == BK_RET) && !ras_empty_i;

  always_comb begin
    next_pc_o = seq_pc(pc_i);
    if (redirect_i) begin
      next_pc_o = redirect_pc_i;
    end else if (hit_i) begin
      unique case (kind_i)
        BK_COND: next_pc_o = taken_i ? target_i : seq_pc(pc_i);
        BK_JUMP: next_pc_o = target_i;
        BK_CALL: next_pc_o = target_i;
        BK_RET:  next_pc_o = ras_empty_i ? target_i : ras_top_i;
        default: next_pc_o = seq_pc(pc_i);
      endcase
    end
  end
endmodule

// File: rtl/next_pc_sel.sv
module next_pc_sel
  import next_pc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          btb_hit_i,
  input  logic [1:0]    btb_kind_i,
  input  logic [AW-1:0] btb_target_i,
  input  logic          dir_taken_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  output logic [AW-1:0] next_pc_o
);
  localparam int CW = $clog2(DEPTH+1);

  // named events for the checker
  logic          push_ev;
  logic          pop_ev;
  logic          ras_empty;
  logic [CW-1:0] ras_count;
  logic [AW-1:0] ras_top;
  logic [AW-1:0] link_addr;
  br_kind_e      kind;

  assign kind = br_kind_e'(btb_kind_i);

  npc_choose #(.AW(AW)) u_choose (
    .pc_i          (pc_i),
    .hit_i         (btb_hit_i),
    .kind_i        (kind),
    .target_i      (btb_target_i),
    .taken_i       (dir_taken_i),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .ras_top_i     (ras_top),
    .ras_empty_i   (ras_empty),
    .next_pc_o     (next_pc_o),
    .link_addr_o   (link_addr),
    .push_o        (push_ev),
    .pop_o         (pop_ev)
  );

  npc_ras #(.AW(AW), .DEPTH(DEPTH)) u_ras (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_ev),
    .pop_i       (pop_ev),
    .push_addr_i (link_addr),
    .top_o       (ras_top),
    .empty_o     (ras_empty),
    .count_o     (ras_count)
  );
endmodule

// File: rtl/next_pc_sel_chk.sv
module next_pc_sel_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              pc_i,
  input logic                       btb_hit_i,
  input logic [1:0]                 btb_kind_i,
  input logic [AW-1:0]              btb_target_i,
  input logic                       redirect_i,
  input logic [AW-1:0]              redirect_pc_i,
  input logic [AW-1:0]              next_pc_o,
  input logic                       push_ev,
  input logic                       pop_ev,
  input logic                       ras_empty,
  input logic [$clog2(DEPTH+1)-1:0] ras_count
);
  localparam int CW = $clog2(DEPTH+1);

  p_miss_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && !btb_hit_i) |-> next_pc_o == pc_i + AW'(4));

  p_jump_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && btb_hit_i && btb_kind_i == 2'b01) |-> (next_pc_o == btb_target_i && !push_ev && !pop_ev));

  p_call_then_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && btb_hit_i && btb_kind_i == 2'b10) ##1 (!redirect_i && btb_hit_i && btb_kind_i == 2'b11)
      |-> next_pc_o == $past(pc_i) + AW'(4));

  p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> ras_count == $past(ras_count) - 1'b1);

  p_full_push_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && ras_count == CW'(DEPTH)) |=> ras_count == CW'(DEPTH));

  p_empty_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && btb_hit_i && btb_kind_i == 2'b11 && ras_empty) |-> (next_pc_o == btb_target_i && !pop_ev));

  p_redirect_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |-> (next_pc_o == redirect_pc_i && !push_ev && !pop_ev));

  p_reset_empty_r10: assert property (@(posedge clk)
    !rst_n |=> ras_empty);
endmodule

bind next_pc_sel next_pc_sel_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_i          (pc_i),
  .btb_hit_i     (btb_hit_i),
  .btb_kind_i    (btb_kind_i),
  .btb_target_i  (btb_target_i),
  .redirect_i    (redirect_i),
  .redirect_pc_i (redirect_pc_i),
  .next_pc_o     (next_pc_o),
  .push_ev       (push_ev),
  .pop_ev        (pop_ev),
  .ras_empty     (ras_empty),
  .ras_count     (ras_count)
);

// File: tb/next_pc_sel_tb.sv
`timescale 1ns/1ps
module next_pc_sel_tb;
  localparam int AW    = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          btb_hit_i = 1'b0;
  logic [1:0]    btb_kind_i = 2'b00;
  logic [AW-1:0] btb_target_i = '0;
  logic          dir_taken_i = 1'b0;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_pc_i = '0;
  logic [AW-1:0] next_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [AW-1:0] model_q [$];

  always #5 clk = ~clk;

  next_pc_sel #(.AW(AW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .btb_hit_i(btb_hit_i),
    .btb_kind_i(btb_kind_i), .btb_target_i(btb_target_i),
    .dir_taken_i(dir_taken_i), .redirect_i(redirect_i),
    .redirect_pc_i(redirect_pc_i), .next_pc_o(next_pc_o)
  );

  function automatic logic [AW-1:0] fall_through(input logic [AW-1:0] p);
    return p + 32'd4;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one fetch cycle at negedge, check output, then let the edge update
  task automatic step(input logic [AW-1:0] pc, input logic hit, input logic [1:0] kind,
                      input logic [AW-1:0] tgt, input logic dir, input logic redir,
                      input logic [AW-1:0] rpc, input string tag_in);
    logic [AW-1:0] exp;
    string tag;
    @(negedge clk);
    pc_i = pc; btb_hit_i = hit; btb_kind_i = kind; btb_target_i = tgt;
    dir_taken_i = dir; redirect_i = redir; redirect_pc_i = rpc;
    tag = tag_in;
    if (redir) begin
      exp = rpc; if (tag == "") tag = "R9";
    end else if (!hit) begin
      exp = fall_through(pc); if (tag == "") tag = "R1";
    end else begin
      case (kind)
        2'b00: begin exp = dir ? tgt : fall_through(pc); if (tag == "") tag = "R3"; end
        2'b01: begin exp = tgt; if (tag == "") tag = "R2"; end
        2'b10: begin exp = tgt; if (tag == "") tag = "R4"; end
        default: begin
          if (model_q.size() > 0) begin
            exp = model_q[$]; if (tag == "") tag = "R5,R6";
          end else begin
            exp = tgt; if (tag == "") tag = "R8";
          end
        end
      endcase
    end
    #2;
    check(next_pc_o, exp, tag);
    if (!redir && hit && kind == 2'b10) begin
      model_q.push_back(fall_through(pc));
      if (model_q.size() > DEPTH) void'(model_q.pop_front());
    end else if (!redir && hit && kind == 2'b11 && model_q.size() > 0) begin
      void'(model_q.pop_back());
    end
  endtask

  function automatic logic [AW-1:0] rand_addr();
    return {$urandom(), 2'b00} & 32'hFFFF_FFFC;
  endfunction

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    // reset: outputs still follow the miss path combinationally
    @(negedge clk); pc_i = 32'h0000_1000; #2;
    check(next_pc_o, 32'h0000_1004, "R1 reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: first return after reset falls back to the buffer target
    step(32'h100, 1, 2'b11, 32'hAAA0, 0, 0, 0, "R10");
    // R6 nesting
    step(32'h200, 1, 2'b10, 32'h3000, 0, 0, 0, "R4");
    step(32'h3000, 1, 2'b10, 32'h4000, 0, 0, 0, "R4");
    step(32'h4000, 1, 2'b10, 32'h5000, 0, 0, 0, "R4");
    // R9: redirect over a return, stack must keep its top
    step(32'h5000, 1, 2'b11, 32'h0, 0, 1, 32'h7770, "R9");
    step(32'h5004, 1, 2'b11, 32'h0, 0, 0, 0, "R6");
    step(32'h4004, 1, 2'b11, 32'h0, 0, 0, 0, "R6");
    step(32'h3004, 1, 2'b11, 32'h0, 0, 0, 0, "R6");
    step(32'h204, 1, 2'b11, 32'hBEE0, 0, 0, 0, "R8");
    // R7: overflow by three, drain DEPTH, then one more falls back
    for (int i = 0; i < DEPTH + 3; i++)
      step(32'h8000 + 32'(i*64), 1, 2'b10, 32'h9000, 1, 0, 0, "R7");
    for (int i = 0; i < DEPTH; i++)
      step(32'h9000, 1, 2'b11, 32'h0, 0, 0, 0, "R7");
    step(32'h9000, 1, 2'b11, 32'hCAFE0, 0, 0, 0, "R7,R8");
    // R2/R3 directed, jump ignores direction
    step(32'h600, 1, 2'b01, 32'h6600, 0, 0, 0, "R2");
    step(32'h600, 1, 2'b00, 32'h6600, 0, 0, 0, "R3");
    step(32'h600, 1, 2'b00, 32'h6600, 1, 0, 0, "R3");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      step(rand_addr(), ($urandom_range(9) < 7), 2'($urandom_range(3)), rand_addr(),
           1'($urandom_range(1)), ($urandom_range(9) == 0), rand_addr(), "");
    end
    finish_run();
  end
endmodule